// File: doc/BRIEF.md
# Serial-to-Parallel Word Demultiplexer with Bit Slip

This block takes a serial bit stream that has already been retimed onto a bit-rate clock and gathers it into parallel words. Each byte of the word gets its own parity bit, and that bit appears together with the word. A one-cycle strobe marks every new word. All logic runs on the single bit-rate clock.

Framing logic upstream looks for a frame pattern in the parallel words. When the pattern is not found, it pulls the slip request low. The block then drops one incoming bit, which moves the word boundary by one bit position. Repeated requests walk the boundary until it lines up with the frame.

Other controls:
- A data-invert input complements every incoming bit.
- A parity-polarity input selects even or odd parity.
- A two-bit mode code selects one of these:
  - full-width words;
  - half-width words that fill only the upper half of the output;
  - a forced all-ones output.

The mode code is treated as static. A change of mode is followed by a reset.

Top module: `serial_word_demux`

## Requirements
- R1: While `rst` is high, `word_out`, `par_out` and `word_stb` are all zero. The first bit sampled after `rst` falls is the first bit of the first word.
- R2: With `mode` = 2'b01, every 32 accepted bits form one word. The earliest bit lands on `word_out[31]` and the latest on `word_out[0]`. Byte 1 is `word_out[31:24]`, the most significant byte.
- R3: `word_stb` is high for exactly one cycle, in the cycle in which `word_out` and `par_out` take a new value. Between strobes both outputs hold their value.
- R4: `par_out[k]` covers `word_out[8k+7:8k]`, so `par_out[3]` belongs to byte 1. With `par_odd_n` = 1 the byte plus its parity bit holds an even number of ones. With `par_odd_n` = 0 it holds an odd number.
- R5: With `inv_n` = 0, every incoming bit is complemented before it enters the word.
- R6: A high-to-low change of `slip_n`, as seen at two successive clock edges, discards the bit presented in that cycle. Keeping `slip_n` low causes no further discards.
- R7: With `mode` = 2'b10, every 16 accepted bits fill `word_out[31:16]`, earliest bit at bit 31. `word_out[15:0]` and `par_out[1:0]` stay zero, and the strobe comes once per 16 accepted bits.
- R8: With `mode` = 2'b00, each word boundary (every 32 accepted bits) loads all ones into `word_out`. Every `par_out` bit is then 0 for even parity and 1 for odd parity.
- R9: The reserved code `mode` = 2'b11 behaves exactly as the 1:32 mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Retimed serial data bit |
| slip_n | input | 1 | Slip request, active low, acted on at its falling transition |
| inv_n | input | 1 | Low complements incoming data |
| par_odd_n | input | 1 | High selects even parity, low selects odd parity |
| mode | input | 2 | 01 = 1:32, 10 = 1:16, 00 = all ones, 11 = reserved (as 1:32) |
| word_out | output | 32 | Parallel word, byte 1 in bits 31:24 |
| par_out | output | 4 | Per-byte parity, bit k covers byte bits 8k+7:8k |
| word_stb | output | 1 | One-cycle pulse when a new word is presented |

## Verification
The assertions check the following on every cycle:
- the strobe is a single-cycle pulse;
- the word and parity hold between strobes;
- each parity bit agrees with its byte under the polarity that was selected;
- the lower half stays zero in half-width mode;
- the all-ones mode presents only ones.

Other properties depend on knowing the input history, so only the bench scenarios can show them:
- the order in which bits land in the word;
- that inversion was applied;
- that exactly one bit is lost per slip edge and none while the request is held low;
- where the word boundary falls after reset.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef enum logic [1:0] {
    MODE_ONES = 2'b00,
    MODE_W32  = 2'b01,
    MODE_W16  = 2'b10,
    MODE_RSVD = 2'b11
  } sdx_mode_e;
endpackage

// File: rtl/sdx_front.sv
// Input conditioning: optional complement and slip falling-edge detection.
module sdx_front (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  input  logic inv_n,
  input  logic slip_n,
  output logic bit_val,
  output logic bit_take
);
  logic slip_q;

  always_ff @(posedge clk) begin
    if (rst) slip_q <= 1'b1;
    else     slip_q <= slip_n;
  end

  // A falling request suppresses acceptance of the current bit only.
  assign bit_val  = ser_in ^ ~inv_n;
  assign bit_take = ~(slip_q & ~slip_n);
endmodule

// File: rtl/sdx_assemble.sv
// Bit counter and shift register that build a word from accepted bits.
module sdx_assemble #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_val,
  input  logic              bit_take,
  input  logic              half_mode,
  output logic              word_done,
  output logic [WORD_W-1:0] word_bits
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int HALF_W = WORD_W / 2;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [WORD_W-2:0] sh;
  logic [WORD_W-1:0] full;

  assign last_idx  = half_mode ? CNT_W'(HALF_W - 1) : CNT_W'(WORD_W - 1);
  assign word_done = bit_take & (cnt == last_idx);
  assign full      = {sh, bit_val};
  assign word_bits = half_mode ? {full[HALF_W-1:0], {HALF_W{1'b0}}} : full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sh  <= '0;
    end else if (bit_take) begin
      sh  <= full[WORD_W-2:0];
      cnt <= word_done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdx_outreg.sv
// Output word register with per-byte parity generation.
module sdx_outreg #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [WORD_W-1:0]        word_bits,
  input  logic                     ones_mode,
  input  logic                     half_mode,
  input  logic                     odd_n,
  output logic [WORD_W-1:0]        word_q,
  output logic [WORD_W/BYTE_W-1:0] par_q,
  output logic                     stb_q
);
  localparam int NBYTE      = WORD_W / BYTE_W;
  localparam int HALF_BYTES = NBYTE / 2;

  logic [WORD_W-1:0] word_src;
  logic [NBYTE-1:0]  par_src;

  assign word_src = ones_mode ? {WORD_W{1'b1}} : word_bits;

  for (genvar g = 0; g < NBYTE; g++) begin : g_par
    if (g < HALF_BYTES) begin : g_low
      assign par_src[g] = half_mode ? 1'b0
                        : ((^word_src[g*BYTE_W +: BYTE_W]) ^ ~odd_n);
    end else begin : g_high
      assign par_src[g] = (^word_src[g*BYTE_W +: BYTE_W]) ^ ~odd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      par_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= load;
      if (load) begin
        word_q <= word_src;
        par_q  <= par_src;
      end
    end
  end
endmodule

// File: rtl/serial_word_demux.sv
module serial_word_demux #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_in,
  input  logic                     slip_n,
  input  logic                     inv_n,
  input  logic                     par_odd_n,
  input  logic [1:0]               mode,
  output logic [WORD_W-1:0]        word_out,
  output logic [WORD_W/BYTE_W-1:0] par_out,
  output logic                     word_stb
);
  import sdx_pkg::*;

  sdx_mode_e         mode_e;
  logic              half_mode;
  logic              ones_mode;
  logic              bit_val;
  logic              bit_take;
  logic              word_done;
  logic [WORD_W-1:0] word_bits;

  assign mode_e    = sdx_mode_e'(mode);
  assign half_mode = (mode_e == MODE_W16);
  assign ones_mode = (mode_e == MODE_ONES);

  sdx_front u_front (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .inv_n   (inv_n),
    .slip_n  (slip_n),
    .bit_val (bit_val),
    .bit_take(bit_take)
  );

  sdx_assemble #(.WORD_W(WORD_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .bit_val  (bit_val),
    .bit_take (bit_take),
    .half_mode(half_mode),
    .word_done(word_done),
    .word_bits(word_bits)
  );

  sdx_outreg #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (word_done),
    .word_bits(word_bits),
    .ones_mode(ones_mode),
    .half_mode(half_mode),
    .odd_n    (par_odd_n),
    .word_q   (word_out),
    .par_q    (par_out),
    .stb_q    (word_stb)
  );
endmodule

// File: rtl/serial_word_demux_chk.sv
module serial_word_demux_chk #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     par_odd_n,
  input logic [1:0]               mode,
  input logic [WORD_W-1:0]        word_out,
  input logic [WORD_W/BYTE_W-1:0] par_out,
  input logic                     word_stb
);
  localparam int NBYTE  = WORD_W / BYTE_W;
  localparam int HALF_W = WORD_W / 2;

  // R3: strobe never lasts two cycles
  a_r3_stb_single: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);

  // R3: word and parity hold between strobes
  a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!word_stb && !$past(rst)) |-> ($stable(word_out) && $stable(par_out)));

  // R4: parity bit matches its byte under the polarity used at load time
  for (genvar g = 0; g < NBYTE; g++) begin : g_pchk
    a_r4_parity_rule: assert property (@(posedge clk) disable iff (rst)
      (word_stb && !$past(rst) && $past(mode) != 2'b10) |->
      (par_out[g] == ((^word_out[g*BYTE_W +: BYTE_W]) ^ !$past(par_odd_n))));
  end

  // R7: lower half and its parity stay zero in half-width mode
  a_r7_lower_zero: assert property (@(posedge clk) disable iff (rst)
    (word_stb && !$past(rst) && $past(mode) == 2'b10) |->
    (word_out[HALF_W-1:0] == '0 && par_out[NBYTE/2-1:0] == '0));

  // R8: all-ones mode presents only ones
  a_r8_all_ones: assert property (@(posedge clk) disable iff (rst)
    (word_stb && !$past(rst) && $past(mode) == 2'b00) |->
    (word_out == {WORD_W{1'b1}}));
endmodule

bind serial_word_demux serial_word_demux_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/serial_word_demux_test.sv
module serial_word_demux_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0;
  logic        slip_n = 1'b1;
  logic        inv_n = 1'b1;
  logic        par_odd_n = 1'b1;
  logic [1:0]  mode = 2'b01;
  logic [31:0] word_out;
  logic [3:0]  par_out;
  logic        word_stb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_word_demux uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .slip_n(slip_n), .inv_n(inv_n),
    .par_odd_n(par_odd_n), .mode(mode), .word_out(word_out),
    .par_out(par_out), .word_stb(word_stb)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [1:0] m, input bit inv, input bit odd,
                          input int slip_pat, input int ncyc, input logic [15:0] seed);
    logic [15:0] lfsr = seed;
    bit q[$];
    int nwlen;
    int cnt = 0;
    bit have_prev = 0;
    bit prev_take = 0;
    bit prev_bit = 0;
    bit prev_slip = 1;
    logic [31:0] last_w = '0;
    logic [3:0]  last_p = '0;
    string wtag;
    nwlen = (m == 2'b10) ? 16 : 32;
    if (slip_pat != 0)      wtag = "R6";
    else if (!inv)          wtag = "R5";
    else if (m == 2'b10)    wtag = "R7";
    else if (m == 2'b00)    wtag = "R8";
    else if (m == 2'b11)    wtag = "R9";
    else                    wtag = "R2";
    // Reset with configuration applied
    @(negedge clk);
    rst = 1'b1; slip_n = 1'b1; mode = m; inv_n = inv; par_odd_n = odd; ser_in = 1'b1;
    repeat (3) @(negedge clk);
    check(word_out == '0, "R1", "reset word", word_out, '0);
    check(par_out == '0, "R1", "reset parity", {28'd0, par_out}, '0);
    check(word_stb == 1'b0, "R1", "reset strobe", {31'd0, word_stb}, '0);
    for (int c = 0; c < ncyc; c++) begin
      if (c != 0) @(negedge clk);
      if (have_prev) begin
        bit hit = 0;
        if (prev_take) begin
          q.push_back(prev_bit ^ !inv);
          cnt++;
          if (cnt == nwlen) begin hit = 1; cnt = 0; end
        end
        if (hit) begin
          logic [31:0] w = '0;
          logic [31:0] ew;
          logic [3:0]  ep;
          for (int k = 0; k < nwlen; k++) w = {w[30:0], q.pop_front()};
          if (m == 2'b10)      ew = {w[15:0], 16'h0};
          else if (m == 2'b00) ew = '1;
          else                 ew = w;
          for (int b = 0; b < 4; b++)
            ep[b] = (m == 2'b10 && b < 2) ? 1'b0 : ((^ew[b*8 +: 8]) ^ !odd);
          check(word_stb == 1'b1, "R3", "strobe at word boundary", {31'd0, word_stb}, 32'd1);
          check(word_out == ew, wtag, "word value", word_out, ew);
          check(par_out == ep, "R4", "parity bits", {28'd0, par_out}, {28'd0, ep});
          last_w = ew; last_p = ep;
        end else begin
          check(word_stb == 1'b0, "R3", "strobe idle", {31'd0, word_stb}, '0);
          check(word_out == last_w && par_out == last_p, "R3", "hold between words",
                word_out, last_w);
        end
      end
      // Drive next cycle
      rst = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser_in = lfsr[0];
      case (slip_pat)
        1: slip_n = !((c % 37) == 20);
        2: slip_n = !((c % 50) >= 15 && (c % 50) < 25);
        default: slip_n = 1'b1;
      endcase
      prev_take = !(prev_slip && !slip_n);
      prev_slip = slip_n;
      prev_bit = ser_in;
      have_prev = 1;
    end
  endtask

  initial begin
    run_case(2'b01, 1, 1, 0, 400, 16'hACE1);
    run_case(2'b01, 0, 0, 0, 400, 16'h1234);
    run_case(2'b01, 1, 1, 1, 400, 16'h5A5A);
    run_case(2'b01, 1, 0, 2, 400, 16'h0F0F);
    run_case(2'b10, 1, 0, 0, 300, 16'hBEEF);
    run_case(2'b10, 0, 1, 1, 300, 16'h7777);
    run_case(2'b00, 1, 1, 0, 200, 16'h4321);
    run_case(2'b00, 1, 0, 1, 200, 16'h9999);
    run_case(2'b11, 1, 1, 0, 300, 16'hC0DE);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule